// File: doc/BRIEF.md
# Dispatch User Register Packer

This block turns the per-dispatch setup of a compute wave into a stream of 32-bit scalar register writes. A start pulse captures a set of ten field enables and the raw dispatch values. The block then walks the fields in a fixed order and gives each enabled field a dense run of register indices beginning at zero. It issues at most one write per cycle, each carrying an index and a data word, and ends the sequence with a one-cycle done pulse. Disabled fields take no index.

Most words are copied from the captured inputs. Three kinds are computed. Each work-group count is the ceiling of the grid size over the work-group size, found by a multi-cycle restoring divider, and the sequence waits for each quotient. The per-item private size is rounded up to a whole dword, and the same rounded value is also the second word of the scratch-init pair. No more than sixteen registers are written: a word that would fall at index sixteen or above is dropped. The final register count is held on an output until the next start.

Top module: `dispatch_ureg_packer`

## Requirements
- R1: Fields are visited in this order, with the enable bit given in brackets and the word count after it: segment buffer descriptor [bit 0] 4, dispatch pointer [bit 1] 2, queue pointer [bit 2] 2, kernel-argument pointer [bit 3] 2, dispatch identifier [bit 4] 2, scratch-init pair [bit 5] 2, private size [bit 6] 1, work-group count X [bit 7] 1, Y [bit 8] 1, Z [bit 9] 1. Descriptor word n is `seg_desc[32n+31:32n]`, and the first scratch-init word is `scratch_off`.
- R2: Register indices are dense: the k-th write of a sequence carries index k, counted from zero, and a disabled field consumes no index.
- R3: No write carries an index of 16 or more. Words past that limit are dropped, and the register count saturates at 16.
- R4: Every 64-bit value (the dispatch, queue and kernel-argument pointers and the dispatch identifier) is written as its low 32 bits first and its high 32 bits in the next write.
- R5: The work-group count word for each dimension equals ceil(grid / wg), computed without overflow for any 32-bit grid and 16-bit wg.
- R6: A work-group size of zero in a dimension gives a count word of zero.
- R7: The private size word and the second scratch-init word both equal `item_priv_bytes` rounded up to the next multiple of 4.
- R8: At done, `reg_count` equals the number of writes in the sequence, and it keeps that value until the next accepted start.
- R9: Each accepted start produces exactly one done pulse, one cycle wide, after the last write. `wr_valid` is low in that cycle.
- R10: A start that arrives while `busy` is high, including the done cycle, is ignored: the running sequence and its captured inputs are unchanged, and no new sequence begins.
- R11: After reset, `busy`, `wr_valid` and `done` are low and `reg_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures all inputs and begins a sequence when idle |
| field_en | input | 10 | Per-field enables (bit positions in R1) |
| seg_desc | input | 128 | Segment buffer descriptor, four words |
| dispatch_ptr | input | 64 | Dispatch packet address |
| queue_ptr | input | 64 | Queue object address |
| kernarg_ptr | input | 64 | Kernel-argument segment address |
| dispatch_id | input | 64 | Dispatch identifier |
| scratch_off | input | 32 | First scratch-init word (scratch byte offset) |
| item_priv_bytes | input | 32 | Per-work-item private size in bytes |
| grid_x | input | 32 | Grid size X |
| grid_y | input | 32 | Grid size Y |
| grid_z | input | 32 | Grid size Z |
| wg_x | input | 16 | Work-group size X |
| wg_y | input | 16 | Work-group size Y |
| wg_z | input | 16 | Work-group size Z |
| busy | output | 1 | Sequence in progress (includes the done cycle) |
| wr_valid | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register index of the write |
| wr_data | output | 32 | Register data of the write |
| done | output | 1 | One-cycle end-of-sequence pulse |
| reg_count | output | 5 | Number of user registers written |

## Verification
The end of a sequence and a new start request can fall in the same cycle. The bench provokes this by raising `start` at the edge where `done` is high, with changed inputs behind it. It judges the outcome by checking that no write appears for many cycles afterwards, that `busy` stays low and that `reg_count` keeps its value. A second overlap occurs when the register limit is reached on the same step where a count field would launch the divider. The full sweep of all enable patterns covers this case, and the expected write list and count are compared word by word.

// File: rtl/ureg_pkg.sv
package ureg_pkg;
  localparam int DW        = 32;
  localparam int NF        = 10;
  localparam int SEG_WORDS = 4;

  localparam logic [3:0] FLD_SEGBUF  = 4'd0;
  localparam logic [3:0] FLD_DPTR    = 4'd1;
  localparam logic [3:0] FLD_QPTR    = 4'd2;
  localparam logic [3:0] FLD_KARG    = 4'd3;
  localparam logic [3:0] FLD_DID     = 4'd4;
  localparam logic [3:0] FLD_SCRATCH = 4'd5;
  localparam logic [3:0] FLD_PSIZE   = 4'd6;
  localparam logic [3:0] FLD_CNTX    = 4'd7;
  localparam logic [3:0] FLD_CNTY    = 4'd8;
  localparam logic [3:0] FLD_CNTZ    = 4'd9;
  localparam logic [3:0] FLD_END     = 4'd10;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_WAIT
  } seq_state_e;

  // words each field occupies in the user register file
  function automatic logic [2:0] fld_words(input logic [3:0] f);
    case (f)
      FLD_SEGBUF:                                        fld_words = 3'(SEG_WORDS);
      FLD_DPTR, FLD_QPTR, FLD_KARG, FLD_DID, FLD_SCRATCH: fld_words = 3'd2;
      default:                                           fld_words = 3'd1;
    endcase
  endfunction

  function automatic logic is_count_fld(input logic [3:0] f);
    is_count_fld = (f == FLD_CNTX) || (f == FLD_CNTY) || (f == FLD_CNTZ);
  endfunction
endpackage

// File: rtl/ureg_divider.sv
// Restoring divider, one quotient bit per cycle; a zero divisor yields zero.
module ureg_divider #(
  parameter int NUM_W = 33,
  parameter int DEN_W = 16,
  parameter int Q_W   = 32,
  parameter int CW    = $clog2(NUM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [NUM_W-1:0] acc_q, acc_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  logic [DEN_W:0]   trial;
  logic             ge;
  logic             last;

  always_comb begin
    trial  = {rem_q, acc_q[NUM_W-1]};
    ge     = (trial >= {1'b0, den_q});
    last   = (cnt_q == CW'(NUM_W - 1));
    run_d  = run_q;
    acc_d  = acc_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (go) begin
      run_d = 1'b1;
      acc_d = num;
      rem_d = '0;
      den_d = den;
      cnt_d = '0;
    end else if (run_q) begin
      acc_d  = {acc_q[NUM_W-2:0], ge};
      rem_d  = ge ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
      cnt_d  = cnt_q + CW'(1);
      if (last) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      acc_q  <= acc_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
    end
  end

  assign done = done_q;
  assign quot = (den_q == '0) ? '0 : acc_q[Q_W-1:0];
endmodule

// File: rtl/ureg_word_mux.sv
// Picks the data word for the current field and word position.
module ureg_word_mux
  import ureg_pkg::*;
(
  input  logic [3:0]              fld,
  input  logic [1:0]              wrd,
  input  logic [SEG_WORDS*DW-1:0] segbuf,
  input  logic [2*DW-1:0]         dptr,
  input  logic [2*DW-1:0]         qptr,
  input  logic [2*DW-1:0]         kptr,
  input  logic [2*DW-1:0]         did,
  input  logic [DW-1:0]           scr_off,
  input  logic [DW-1:0]           psz_rnd,
  input  logic [DW-1:0]           quot,
  output logic [DW-1:0]           data
);
  function automatic logic [DW-1:0] half(input logic [2*DW-1:0] v, input logic hi);
    half = hi ? v[2*DW-1:DW] : v[DW-1:0];
  endfunction

  always_comb begin
    case (fld)
      FLD_SEGBUF:  data = segbuf[wrd*DW +: DW];
      FLD_DPTR:    data = half(dptr, wrd[0]);
      FLD_QPTR:    data = half(qptr, wrd[0]);
      FLD_KARG:    data = half(kptr, wrd[0]);
      FLD_DID:     data = half(did, wrd[0]);
      FLD_SCRATCH: data = wrd[0] ? psz_rnd : scr_off;
      FLD_PSIZE:   data = psz_rnd;
      FLD_CNTX, FLD_CNTY, FLD_CNTZ: data = quot;
      default:     data = '0;
    endcase
  end
endmodule

// File: rtl/ureg_sequencer.sv
// Walks the fields, allocates dense indices, stalls on the divider.
module ureg_sequencer
  import ureg_pkg::*;
#(
  parameter int CAP = 16,
  parameter int IW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NF-1:0] en,
  input  logic          div_done,
  output logic          accept,
  output logic          div_go,
  output logic [1:0]    dim,
  output logic [3:0]    fld,
  output logic [1:0]    wrd,
  output logic          wr_valid,
  output logic [IW-1:0] wr_idx,
  output logic          done,
  output logic          busy,
  output logic [IW-1:0] reg_count
);
  seq_state_e    st_q, st_d;
  logic [3:0]    fld_q, fld_d;
  logic [1:0]    wrd_q, wrd_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          qrdy_q, qrdy_d;
  logic          last_word;

  always_comb begin
    st_d      = st_q;
    fld_d     = fld_q;
    wrd_d     = wrd_q;
    idx_d     = idx_q;
    qrdy_d    = qrdy_q;
    accept    = 1'b0;
    div_go    = 1'b0;
    wr_valid  = 1'b0;
    done      = 1'b0;
    last_word = ({1'b0, wrd_q} == (fld_words(fld_q) - 3'd1));
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          accept = 1'b1;
          st_d   = SEQ_RUN;
          fld_d  = '0;
          wrd_d  = '0;
          idx_d  = '0;
          qrdy_d = 1'b0;
        end
      end
      SEQ_RUN: begin
        if (fld_q == FLD_END) begin
          done = 1'b1;
          st_d = SEQ_IDLE;
        end else if (!en[fld_q] || (idx_q == IW'(CAP))) begin
          // disabled field, or limit reached: skip without launching work
          fld_d  = fld_q + 4'd1;
          wrd_d  = '0;
          qrdy_d = 1'b0;
        end else if (is_count_fld(fld_q) && !qrdy_q) begin
          div_go = 1'b1;
          st_d   = SEQ_WAIT;
        end else begin
          wr_valid = 1'b1;
          idx_d    = idx_q + IW'(1);
          if (last_word) begin
            fld_d  = fld_q + 4'd1;
            wrd_d  = '0;
            qrdy_d = 1'b0;
          end else begin
            wrd_d = wrd_q + 2'd1;
          end
        end
      end
      SEQ_WAIT: begin
        if (div_done) begin
          qrdy_d = 1'b1;
          st_d   = SEQ_RUN;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      fld_q  <= '0;
      wrd_q  <= '0;
      idx_q  <= '0;
      qrdy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fld_q  <= fld_d;
      wrd_q  <= wrd_d;
      idx_q  <= idx_d;
      qrdy_q <= qrdy_d;
    end
  end

  // count fields 7,8,9 map to dimensions 0,1,2
  assign dim       = fld_q[1:0] + 2'd1;
  assign fld       = fld_q;
  assign wrd       = wrd_q;
  assign wr_idx    = idx_q;
  assign reg_count = idx_q;
  assign busy      = (st_q != SEQ_IDLE);
endmodule

// File: rtl/dispatch_ureg_packer.sv
module dispatch_ureg_packer
  import ureg_pkg::*;
#(
  parameter int USER_CAP = 16,
  parameter int WG_W     = 16,
  parameter int IDX_W    = $clog2(USER_CAP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NF-1:0]           field_en,
  input  logic [SEG_WORDS*DW-1:0] seg_desc,
  input  logic [2*DW-1:0]         dispatch_ptr,
  input  logic [2*DW-1:0]         queue_ptr,
  input  logic [2*DW-1:0]         kernarg_ptr,
  input  logic [2*DW-1:0]         dispatch_id,
  input  logic [DW-1:0]           scratch_off,
  input  logic [DW-1:0]           item_priv_bytes,
  input  logic [DW-1:0]           grid_x,
  input  logic [DW-1:0]           grid_y,
  input  logic [DW-1:0]           grid_z,
  input  logic [WG_W-1:0]         wg_x,
  input  logic [WG_W-1:0]         wg_y,
  input  logic [WG_W-1:0]         wg_z,
  output logic                    busy,
  output logic                    wr_valid,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [DW-1:0]           wr_data,
  output logic                    done,
  output logic [IDX_W-1:0]        reg_count
);
  localparam int NUM_W = DW + 1;

  logic                    accept;
  logic                    div_go, div_done;
  logic [1:0]              dim, dsel;
  logic [3:0]              fld;
  logic [1:0]              wrd;
  logic [DW-1:0]           quot;
  logic [NUM_W-1:0]        div_num;
  logic [WG_W-1:0]         div_den;
  logic [DW-1:0]           psz_rnd_in;

  logic [NF-1:0]           en_q;
  logic [SEG_WORDS*DW-1:0] seg_q;
  logic [2*DW-1:0]         dptr_q, qptr_q, kptr_q, did_q;
  logic [DW-1:0]           scr_q, psz_q;
  logic [2:0][DW-1:0]      grid_q;
  logic [2:0][WG_W-1:0]    wg_q;

  assign psz_rnd_in = (item_priv_bytes + DW'(3)) & ~DW'(3);

  // capture registers, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      seg_q  <= '0;
      dptr_q <= '0;
      qptr_q <= '0;
      kptr_q <= '0;
      did_q  <= '0;
      scr_q  <= '0;
      psz_q  <= '0;
      grid_q <= '0;
      wg_q   <= '0;
    end else if (accept) begin
      en_q   <= field_en;
      seg_q  <= seg_desc;
      dptr_q <= dispatch_ptr;
      qptr_q <= queue_ptr;
      kptr_q <= kernarg_ptr;
      did_q  <= dispatch_id;
      scr_q  <= scratch_off;
      psz_q  <= psz_rnd_in;
      grid_q <= {grid_z, grid_y, grid_x};
      wg_q   <= {wg_z, wg_y, wg_x};
    end
  end

  assign dsel    = (dim == 2'd3) ? 2'd0 : dim;
  assign div_num = {1'b0, grid_q[dsel]} + NUM_W'(wg_q[dsel]) - NUM_W'(1);
  assign div_den = wg_q[dsel];

  ureg_sequencer #(.CAP(USER_CAP), .IW(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .en        (en_q),
    .div_done  (div_done),
    .accept    (accept),
    .div_go    (div_go),
    .dim       (dim),
    .fld       (fld),
    .wrd       (wrd),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .done      (done),
    .busy      (busy),
    .reg_count (reg_count)
  );

  ureg_divider #(.NUM_W(NUM_W), .DEN_W(WG_W), .Q_W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quot  (quot)
  );

  ureg_word_mux u_mux (
    .fld     (fld),
    .wrd     (wrd),
    .segbuf  (seg_q),
    .dptr    (dptr_q),
    .qptr    (qptr_q),
    .kptr    (kptr_q),
    .did     (did_q),
    .scr_off (scr_q),
    .psz_rnd (psz_q),
    .quot    (quot),
    .data    (wr_data)
  );
endmodule

// File: rtl/dispatch_ureg_packer_chk.sv
module dispatch_ureg_packer_chk #(
  parameter int CAP = 16,
  parameter int IW  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          wr_valid,
  input logic [IW-1:0] wr_idx,
  input logic          done,
  input logic [IW-1:0] reg_count
);
  logic [IW-1:0] wcnt;

  // independent tally of writes since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (start && !busy) wcnt <= '0;
    else if (wr_valid) wcnt <= wcnt + IW'(1);
  end

  AST_IDX_BELOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_idx < IW'(CAP))); // R3
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_count <= IW'(CAP)); // R3
  AST_IDX_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_idx == wcnt)); // R2
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reg_count == wcnt)); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !done)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (reg_count >= $past(reg_count))); // R10
endmodule

bind dispatch_ureg_packer dispatch_ureg_packer_chk #(.CAP(USER_CAP), .IW(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .wr_valid  (wr_valid),
  .wr_idx    (wr_idx),
  .done      (done),
  .reg_count (reg_count)
);

// File: tb/dispatch_ureg_packer_test.sv
module dispatch_ureg_packer_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [9:0]   field_en;
  logic [127:0] seg_desc;
  logic [63:0]  dispatch_ptr, queue_ptr, kernarg_ptr, dispatch_id;
  logic [31:0]  scratch_off, item_priv_bytes, grid_x, grid_y, grid_z;
  logic [15:0]  wg_x, wg_y, wg_z;
  logic         busy, wr_valid, done;
  logic [4:0]   wr_idx, reg_count;
  logic [31:0]  wr_data;

  always #4 clk = ~clk;

  dispatch_ureg_packer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .field_en(field_en),
    .seg_desc(seg_desc), .dispatch_ptr(dispatch_ptr), .queue_ptr(queue_ptr),
    .kernarg_ptr(kernarg_ptr), .dispatch_id(dispatch_id), .scratch_off(scratch_off),
    .item_priv_bytes(item_priv_bytes), .grid_x(grid_x), .grid_y(grid_y), .grid_z(grid_z),
    .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z), .busy(busy), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .reg_count(reg_count)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] exp_d [16];
  string       exp_tag [16];
  int          exp_n, exp_total;

  logic [31:0] got_d [16];
  logic [4:0]  got_i [16];
  int          got_n, done_seen;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(0, "R9", "watchdog expired", 64'(cyc), 64'd190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (got_n < 16) begin
          got_d[got_n] = wr_data;
          got_i[got_n] = wr_idx;
        end
        got_n++;
      end
      if (done) done_seen++;
    end
  end

  function automatic logic [31:0] ceil_div(input logic [31:0] g, input logic [15:0] w);
    longint unsigned gg, ww;
    gg = 64'(g);
    ww = 64'(w);
    if (ww == 0) return 32'd0;
    return 32'((gg + ww - 1) / ww);
  endfunction

  task automatic push(input logic [31:0] d, input string tag);
    if (exp_total < 16) begin
      exp_d[exp_total]   = d;
      exp_tag[exp_total] = tag;
      exp_n              = exp_total + 1;
    end
    exp_total++;
  endtask

  task automatic build_expected(input logic [9:0] en);
    logic [31:0] rnd;
    rnd = (item_priv_bytes + 32'd3) & ~32'd3;
    exp_n = 0;
    exp_total = 0;
    if (en[0]) for (int w = 0; w < 4; w++) push(seg_desc[32*w +: 32], "R1");
    if (en[1]) begin push(dispatch_ptr[31:0], "R4"); push(dispatch_ptr[63:32], "R4"); end
    if (en[2]) begin push(queue_ptr[31:0], "R4");    push(queue_ptr[63:32], "R4");    end
    if (en[3]) begin push(kernarg_ptr[31:0], "R4");  push(kernarg_ptr[63:32], "R4");  end
    if (en[4]) begin push(dispatch_id[31:0], "R4");  push(dispatch_id[63:32], "R4");  end
    if (en[5]) begin push(scratch_off, "R1");        push(rnd, "R7");                 end
    if (en[6]) push(rnd, "R7");
    if (en[7]) push(ceil_div(grid_x, wg_x), (wg_x == 0) ? "R6" : "R5");
    if (en[8]) push(ceil_div(grid_y, wg_y), (wg_y == 0) ? "R6" : "R5");
    if (en[9]) push(ceil_div(grid_z, wg_z), (wg_z == 0) ? "R6" : "R5");
  endtask

  task automatic set_vals(input int i);
    for (int w = 0; w < 4; w++) seg_desc[32*w +: 32] = 32'hC300_0000 + 32'(i * 4 + w);
    dispatch_ptr    = {32'h1100_0000 ^ 32'(i), 32'h2200_0000 + 32'(i)};
    queue_ptr       = {32'h3300_0000 + 32'(i), 32'h4400_0000 ^ 32'(i)};
    kernarg_ptr     = {32'h6600_0000 + 32'(i * 3), 32'h7700_0000 + 32'(i)};
    dispatch_id     = {32'h8800_0000 + 32'(i), 32'h9900_0000 + 32'(i * 5)};
    scratch_off     = 32'h5500_0000 + 32'(i);
    item_priv_bytes = 32'(i * 13);
    grid_x          = 32'(i * 37 + 1);
    grid_y          = 32'(i * 5);
    grid_z          = 32'(1000 + i);
    wg_x            = 16'(i % 7);
    wg_y            = 16'(1 + (i % 3) * 64);
    wg_z            = 16'((i % 11) + 1);
  endtask

  // mode 0: plain; 1: start pulse mid-run; 2: start on the done edge
  task automatic run_case(input logic [9:0] en, input int mode);
    bit seen;
    int held_n;
    logic [4:0] held_cnt;
    @(negedge clk);
    field_en = en;
    build_expected(en);
    got_n = 0;
    done_seen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 800; k++) begin
      if (done) begin
        seen = 1;
        if (mode == 2) start = 1'b1;
        break;
      end
      if (mode == 1 && k == 5) begin
        start = 1'b1;
        field_en = ~en;
        grid_x = 32'd12345;
        wg_x = 16'd2;
        item_priv_bytes = 32'd999;
      end else if (mode == 1 && k == 6) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(seen, "R9", "done observed", 64'(seen), 64'd1);
    @(negedge clk);
    start = 1'b0;
    if (mode == 2) begin
      held_n = got_n;
      held_cnt = reg_count;
      for (int k = 0; k < 40; k++) @(negedge clk);
      chk(got_n == held_n, "R10", "writes after start in done cycle", 64'(got_n), 64'(held_n));
      chk(!busy, "R10", "busy after start in done cycle", 64'(busy), 64'd0);
      chk(reg_count == held_cnt, "R10", "count held", 64'(reg_count), 64'(held_cnt));
    end else begin
      @(negedge clk);
    end
    chk(got_n == exp_n, (exp_total > 16) ? "R3" : "R2", "write count", 64'(got_n), 64'(exp_n));
    for (int k = 0; k < 16; k++) begin
      if (k < exp_n && k < got_n) begin
        chk(got_i[k] == 5'(k), "R2", "write index", 64'(got_i[k]), 64'(k));
        chk(got_d[k] == exp_d[k], exp_tag[k], "write data", 64'(got_d[k]), 64'(exp_d[k]));
      end
    end
    chk(reg_count == 5'(exp_n), "R8", "reg_count", 64'(reg_count), 64'(exp_n));
    chk(done_seen == 1, "R9", "done pulse count", 64'(done_seen), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    field_en = '0;
    set_vals(0);
    got_n = 0;
    done_seen = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !wr_valid && !done, "R11", "reset outputs", {busy, wr_valid, done}, 3'b000);
    chk(reg_count == 0, "R11", "reset count", 64'(reg_count), 64'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7: sweep every enable pattern
    for (int i = 0; i < 1024; i++) begin
      set_vals(i);
      run_case(10'(i), 0);
    end

    // R7 rounding corners
    for (int p = 0; p < 9; p++) begin
      set_vals(p);
      item_priv_bytes = 32'(p) + 32'h0000_1000;
      run_case(10'b00_0110_0000, 0);
    end

    // R5 R6 divider corners
    set_vals(3);
    grid_x = 32'hFFFF_FFFF; wg_x = 16'd1;
    grid_y = 32'hFFFF_FFFF; wg_y = 16'hFFFF;
    grid_z = 32'd0;         wg_z = 16'd5;
    run_case(10'b11_1000_0000, 0);
    set_vals(4);
    wg_x = 16'd0; wg_y = 16'd0; wg_z = 16'd0;
    run_case(10'b11_1000_0000, 0);

    // R10 start while busy, and start on the done edge
    set_vals(77);
    run_case(10'h3FF, 1);
    set_vals(78);
    run_case(10'b11_1100_0001, 1);
    set_vals(79);
    run_case(10'h3FF, 2);
    set_vals(80);
    run_case(10'b10_0000_0010, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule